// File: doc/BRIEF.md
# Countdown Timer With Register Bus and Interrupt

This block is a 32-bit down-counter that software controls through four word registers on a simple request/response bus. Software writes a reload value and a control word. While the run bit is set, every pulse on the tick-enable input moves the live count down by one. When the count sits at zero, the next tick either refills it from the reload register or leaves it at zero. The choice depends on one control bit. That same bit also gates the single interrupt output.

The bus carries whole 32-bit words. The byte at the lowest address sits in bits 31..24, so the most significant byte comes first. Any other transfer size is refused. Writes take effect at the clock edge of the request. Read data comes back one cycle later on a registered port. A refused access raises an error flag in the same cycle and changes nothing. The tick input can be driven every clock or as a slower strobe.

Top module: `tmr_countdown`

## Requirements
- R1: After a synchronous active-low reset, the status, control, reload and live count registers all read 0 and the interrupt output is 0.
- R2: The status register at byte offset 0x0 is plain storage. A read returns exactly the last 32-bit value written, and reading it changes nothing.
- R3: A valid read request places the addressed register on the read-data port one cycle later, together with a one-cycle read-valid. The map is: status 0x0, control 0x4, reload value 0x8, live count 0xC.
- R4: An access is refused if it writes offset 0xC, uses an address above 0xC, uses an address that is not a multiple of 4, or has a byte count other than 4. A refused access asserts the error output in the same cycle, changes no register and produces no read-valid.
- R5: The live count changes only on a clock where the tick-enable input is 1 and control bit 2 (run) is 1.
- R6: On a counting tick, a nonzero count decreases by exactly one.
- R7: On a counting tick, a zero count is refilled from the reload register when control bit 0 (repeat) is 1. When bit 0 is 0, the count stays at zero.
- R8: The interrupt output is a register. It is updated on every tick, whether or not the timer is running, to 1 exactly when the post-tick count is zero and control bit 0 is 1. It holds its value between ticks.
- R9: Writing the reload register does not alter the live count. The new value is used only at the next refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle count strobe |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_nbytes | input | 3 | Transfer size in bytes; only 4 is accepted |
| bus_wdata | input | 32 | Write data, lowest-address byte in bits 31..24 |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_err | output | 1 | Refused access, same cycle as the request |
| irq | output | 1 | Registered interrupt |

## Verification
Register accesses come from a table of vectors. The table mixes legal reads and writes with each kind of refused access: a write to the count offset, an out-of-map address, a misaligned address and a wrong transfer size. Each refused access is followed by a read-back, which shows whether it was rejected silently or actually corrupted state. The counting function is then tried under four patterns. Repeating mode with a small reload value shows the full wrap and when the interrupt fires. One-shot mode after a single load shows that the count stalls at zero with no interrupt. Ticks with the run bit clear show that the interrupt follows ticks while the count does not move. A reload-value change in the middle of a count separates a later refill from a direct load. Idle clocks without ticks, and a zero reload value, cover the remaining edges.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types for the countdown timer.
// Assumes a 32-bit word bus with byte addressing.
package tmr_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned WORD_B   = DATA_W / 8;
    localparam int unsigned WORD_LSB = $clog2(WORD_B);
    localparam int unsigned NREGS    = 4;
    localparam int unsigned SEL_W    = $clog2(NREGS);
    localparam int unsigned MAP_BITS = WORD_LSB + SEL_W;

    // Control bit positions (behavioural: decoded by the counter).
    localparam int unsigned CTL_REPEAT = 0;
    localparam int unsigned CTL_RUN    = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_RELD = 2'd2,
        SEL_LIVE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_busdec.sv
// Module: tmr_busdec
// Decodes one bus request into register strobes or an error.
// Purely combinational. Assumes the request is held for one cycle.
module tmr_busdec
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NB_W   = 3
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB_W-1:0]   nbytes,
    output logic              wr_stat,
    output logic              wr_ctrl,
    output logic              wr_reld,
    output logic              rd_ok,
    output reg_sel_e          sel,
    output logic              acc_err
);
    logic aligned, in_map, size_ok, legal;

    // Classify the address and the transfer size.
    always_comb begin
        aligned = (addr[WORD_LSB-1:0] == '0);
        in_map  = ((addr >> MAP_BITS) == '0);
        size_ok = (nbytes == NB_W'(WORD_B));
        sel     = reg_sel_e'(addr[MAP_BITS-1:WORD_LSB]);
        legal   = aligned && in_map && size_ok && !(we && sel == SEL_LIVE);
    end

    // Produce strobes for legal accesses and the error for the rest.
    always_comb begin
        acc_err = req && !legal;
        wr_stat = req && legal && we && (sel == SEL_STAT);
        wr_ctrl = req && legal && we && (sel == SEL_CTRL);
        wr_reld = req && legal && we && (sel == SEL_RELD);
        rd_ok   = req && legal && !we;
    end
endmodule

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Holds status, control and reload registers and the registered read port.
// Assumes strobes come from tmr_busdec and are mutually exclusive.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_ctrl,
    input  logic              wr_reld,
    input  logic              rd_ok,
    input  logic              acc_err,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] live_cnt,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] reld_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] rd_mux;

    // Store software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ctrl_q <= '0;
            reld_q <= '0;
        end else begin
            if (wr_stat) stat_q <= wdata;
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_reld) reld_q <= wdata;
        end
    end

    // Select the register being read.
    always_comb begin
        unique case (sel)
            SEL_STAT: rd_mux = stat_q;
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_RELD: rd_mux = reld_q;
            default:  rd_mux = live_cnt;
        endcase
    end

    // Register the read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_ok;
            if (rd_ok) rdata_q <= rd_mux;
        end
    end

    a_r4_err_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> ($stable(stat_q) && $stable(ctrl_q) && $stable(reld_q)));
    a_r4_err_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> !rvalid_q);
    a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rvalid_q);
endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// Live down-counter with optional refill, plus the registered interrupt.
// Assumes tick is a single-cycle strobe and the control inputs are registered.
module tmr_count
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              repeat_en,
    input  logic [DATA_W-1:0] reld,
    output logic [DATA_W-1:0] cnt_q,
    output logic              irq_q
);
    logic [DATA_W-1:0] cnt_nxt;

    // Work out the count that follows this cycle.
    always_comb begin
        cnt_nxt = cnt_q;
        if (tick && run) begin
            if (cnt_q != '0)    cnt_nxt = cnt_q - 1'b1;
            else if (repeat_en) cnt_nxt = reld;
        end
    end

    // Update the count and refresh the interrupt on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (tick) irq_q <= (cnt_nxt == '0) && repeat_en;
        end
    end

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && run) |=> $stable(cnt_q));
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    a_r7_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && cnt_q == '0 && repeat_en) |=> (cnt_q == $past(reld)));
    a_r7_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && cnt_q == '0 && !repeat_en) |=> (cnt_q == '0));
    a_r8_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (irq_q == ((cnt_q == '0) && $past(repeat_en))));
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(irq_q));
endmodule

// File: rtl/tmr_countdown.sv
// Module: tmr_countdown (top)
// Countdown timer with a four-register word bus and one interrupt.
// Assumes full-word accesses; a control write applies from the next cycle.
module tmr_countdown
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NB_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NB_W-1:0]   bus_nbytes,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              irq
);
    logic              wr_stat, wr_ctrl, wr_reld, rd_ok;
    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_q, reld_q, cnt_q;

    tmr_busdec #(.ADDR_W(ADDR_W), .NB_W(NB_W)) u_dec (
        .req(bus_req), .we(bus_we), .addr(bus_addr), .nbytes(bus_nbytes),
        .wr_stat(wr_stat), .wr_ctrl(wr_ctrl), .wr_reld(wr_reld),
        .rd_ok(rd_ok), .sel(sel), .acc_err(bus_err)
    );

    tmr_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(wr_stat), .wr_ctrl(wr_ctrl), .wr_reld(wr_reld),
        .rd_ok(rd_ok), .acc_err(bus_err), .sel(sel),
        .wdata(bus_wdata), .live_cnt(cnt_q),
        .ctrl_q(ctrl_q), .reld_q(reld_q),
        .rdata_q(bus_rdata), .rvalid_q(bus_rvalid)
    );

    tmr_count u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .run(ctrl_q[CTL_RUN]), .repeat_en(ctrl_q[CTL_REPEAT]),
        .reld(reld_q), .cnt_q(cnt_q), .irq_q(irq)
    );

    a_r9_reload_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reld && !tick_en) |=> $stable(cnt_q));
endmodule

// File: tb/tmr_countdown_bench.sv
`timescale 1ns/1ps
module tmr_countdown_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_nbytes = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_countdown u_tmr_countdown (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_nbytes(bus_nbytes), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .bus_err(bus_err), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  nb;
        logic        err;
        logic [31:0] rd;
        logic [3:0]  req_id;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 8'h00, 32'hDEADBEEF, 3'd4, 1'b0, 32'h0,        4'd2},
        '{1'b0, 8'h00, 32'h0,        3'd4, 1'b0, 32'hDEADBEEF, 4'd2},
        '{1'b1, 8'h08, 32'h00000005, 3'd4, 1'b0, 32'h0,        4'd3},
        '{1'b0, 8'h08, 32'h0,        3'd4, 1'b0, 32'h00000005, 4'd3},
        '{1'b1, 8'h0C, 32'h00000123, 3'd4, 1'b1, 32'h0,        4'd4},
        '{1'b0, 8'h0C, 32'h0,        3'd4, 1'b0, 32'h00000000, 4'd4},
        '{1'b1, 8'h10, 32'h00000001, 3'd4, 1'b1, 32'h0,        4'd4},
        '{1'b0, 8'h10, 32'h0,        3'd4, 1'b1, 32'h0,        4'd4},
        '{1'b1, 8'h00, 32'h00000011, 3'd2, 1'b1, 32'h0,        4'd4},
        '{1'b1, 8'h02, 32'h00000022, 3'd4, 1'b1, 32'h0,        4'd4},
        '{1'b0, 8'h00, 32'h0,        3'd4, 1'b0, 32'hDEADBEEF, 4'd4},
        '{1'b1, 8'h04, 32'h000000F0, 3'd4, 1'b0, 32'h0,        4'd3},
        '{1'b0, 8'h04, 32'h0,        3'd4, 1'b0, 32'h000000F0, 4'd3},
        '{1'b0, 8'h04, 32'h0,        3'd1, 1'b1, 32'h0,        4'd4},
        '{1'b1, 8'h00, 32'h00000000, 3'd4, 1'b0, 32'h0,        4'd2},
        '{1'b0, 8'h00, 32'h0,        3'd4, 1'b0, 32'h00000000, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [2:0] nb, output logic e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_nbytes = nb;
        #1 e = bus_err;
        @(posedge clk);
        #1 bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [2:0] nb,
                            output logic [31:0] d, output logic e, output logic v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_nbytes = nb;
        #1 e = bus_err;
        @(posedge clk);
        #1 bus_req = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic e;
        bus_write(a, d, 3'd4, e);
    endtask

    function automatic logic [31:0] rd_now_dummy(input logic [31:0] x);
        return x;
    endfunction

    task automatic read_live(output logic [31:0] d);
        logic e, v;
        bus_read(8'h0C, 3'd4, d, e, v);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    // One tick, then compare the live count and the interrupt.
    task automatic tick_and_check(input string req, input logic [31:0] exp_cnt,
                                  input logic exp_irq);
        logic [31:0] c;
        pulse_tick();
        check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq});
        read_live(c);
        check({req, " count"}, c, exp_cnt);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic e, v;

        do_reset();
        // R1: reset state of every register and the interrupt.
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 16; a += 4) begin
            bus_read(8'(a), 3'd4, d, e, v);
            check("R1 reg", d, 32'd0);
            check("R3 rvalid", {31'd0, v}, 32'd1);
        end

        // Table of bus vectors (R2, R3, R4).
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req_id, i);
            if (VECS[i].we) begin
                bus_write(VECS[i].addr, VECS[i].data, VECS[i].nb, e);
                check({tag, " err"}, {31'd0, e}, {31'd0, VECS[i].err});
            end else begin
                bus_read(VECS[i].addr, VECS[i].nb, d, e, v);
                check({tag, " err"}, {31'd0, e}, {31'd0, VECS[i].err});
                check({tag, " rvalid"}, {31'd0, v}, {31'd0, !VECS[i].err});
                if (!VECS[i].err) check({tag, " data"}, d, VECS[i].rd);
            end
        end

        // R6 R7 R8: repeating mode with reload value 3.
        do_reset();
        wr(8'h08, 32'd3);
        wr(8'h04, 32'h5);
        tick_and_check("R7 refill", 32'd3, 1'b0);
        tick_and_check("R6 dec", 32'd2, 1'b0);
        tick_and_check("R6 dec", 32'd1, 1'b0);
        tick_and_check("R8 zero irq", 32'd0, 1'b1);
        tick_and_check("R7 wrap", 32'd3, 1'b0);

        // R5: idle clocks without a tick leave the count alone.
        repeat (5) @(posedge clk);
        #1 check("R8 irq held", {31'd0, irq}, 32'd0);
        read_live(d);
        check("R5 no tick", d, 32'd3);

        // R7: one-shot stalls at zero with no interrupt.
        do_reset();
        wr(8'h08, 32'd2);
        wr(8'h04, 32'h5);
        tick_and_check("R7 load", 32'd2, 1'b0);
        wr(8'h04, 32'h4);
        tick_and_check("R6 oneshot", 32'd1, 1'b0);
        tick_and_check("R7 oneshot zero", 32'd0, 1'b0);
        tick_and_check("R7 oneshot stay", 32'd0, 1'b0);

        // R5 R8: run bit clear, repeat set: count frozen, irq follows ticks.
        do_reset();
        wr(8'h08, 32'd7);
        wr(8'h04, 32'h1);
        tick_and_check("R5 R8 stopped", 32'd0, 1'b1);
        wr(8'h04, 32'h0);
        tick_and_check("R8 cleared", 32'd0, 1'b0);

        // R9: reload change mid-count does not touch the live count.
        do_reset();
        wr(8'h08, 32'd10);
        wr(8'h04, 32'h5);
        tick_and_check("R9 load", 32'd10, 1'b0);
        tick_and_check("R9 dec", 32'd9, 1'b0);
        wr(8'h08, 32'd2);
        read_live(d);
        check("R9 untouched", d, 32'd9);
        tick_and_check("R9 dec after", 32'd8, 1'b0);

        // R7 R8: zero reload value keeps the count at zero with irq high.
        do_reset();
        wr(8'h04, 32'h5);
        tick_and_check("R7 zero reload", 32'd0, 1'b1);
        tick_and_check("R8 zero reload", 32'd0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule